// File: doc/BRIEF.md
# Multi-Stream Line Prefetcher

This block watches a stream of memory accesses, each given as a cache-line number (32-byte lines) with an access kind, and learns runs of neighbouring lines that move steadily up or down through memory. Several such runs are followed at the same time, one table entry per run. A run may skip a single line now and then and still count. Accesses that jump further, or that keep skipping, do not build a run.

Once a run has collected enough steps, every further step in it proposes the next line in the run's direction. A proposal is first put to the second-level cache as a presence query. Only a line that the cache reports absent is then issued as a prefetch request to memory. A proposal that would leave the current 4 KB page (128 lines) is dropped. A new access that fits no tracked run takes over the entry that has gone unused the longest.

Top module: `pf_stream_prefetcher`

## Requirements
- R1: After reset, `l2q_valid` and `pf_valid` are low, and stay low until a run has been confirmed.
- R2: In an ascending run of one-line steps, the fifth access (the fourth step) and every later step of that run raise `l2q_valid` in the next cycle, with `l2q_line` equal to the accessed line plus one.
- R3: In a descending run of one-line steps, the same rule holds with `l2q_line` equal to the accessed line minus one.
- R4: A step of exactly two lines in the run's direction counts as a step but is recorded as a gap. Lines 1,2,4,5,6 therefore query line 7 at the access to line 6.
- R5: A second gap restarts the entry at the new line with no steps counted. A jump of three or more lines starts a separate entry. Neither line pattern 1,3,6,9 nor 1,3,5,7,9,11 produces any query.
- R6: A repeated access to a run's current line does not change its step count and produces no query.
- R7: Access kinds are encoded 0 = load, 1 = store, 2 = instruction fetch. Each entry belongs to one kind, so an access only joins an entry of its own kind, and runs of all three kinds can be confirmed.
- R8: `pf_valid` rises exactly one cycle after a query that met `l2_hit` low, with `pf_line` equal to the queried line. A query that met `l2_hit` high issues no prefetch.
- R9: A proposed line whose 4 KB page (line bits above bit 6) differs from that of the triggering access is suppressed: there is no query and no prefetch.
- R10: Eight runs whose accesses are interleaved are tracked independently, and each is confirmed on its own fifth access.
- R11: An access that matches no entry replaces the least-recently-used entry. An evicted run must rebuild its step count from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_line | input | 26 | Cache-line number of the access (byte address divided by 32) |
| acc_kind | input | 2 | Access kind: 0 load, 1 store, 2 instruction fetch |
| l2_hit | input | 1 | Second-level cache presence reply for the current query |
| l2q_valid | output | 1 | Presence query to the second-level cache |
| l2q_line | output | 26 | Line being queried |
| pf_valid | output | 1 | Prefetch request to memory |
| pf_line | output | 26 | Line to prefetch |

## Verification
A corrupted entry (a wrong step count, direction, gap flag or kind) only shows at the ports when its run next reaches the confirmation point. That shows up as a query that comes one access early or late, points the wrong way, or is missing. The directed sequences are therefore built so that every scenario's decisive access lands exactly on the fourth step, or one access short of it, and the query is sampled one cycle after that access. A wrong replacement choice stays hidden until an evicted run is resumed, so the replacement test returns to both the kept run and the evicted run right after an eviction.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int LINE_W    = 26;
    localparam int CONF_HITS = 4;
    localparam int CNT_W     = $clog2(CONF_HITS + 1);
    localparam int PAGE_LOG2 = 7;

    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic             valid;
        logic [1:0]       kind;
        line_t            last;
        logic             dir_known;
        logic             up;
        logic [CNT_W-1:0] hits;
        logic             gapped;
    } stream_t;

    typedef struct packed {
        logic hit;   // access belongs to this entry
        logic same;  // access repeats the current line
        logic far;   // step of two lines
        logic up;    // step goes towards higher lines
    } cls_t;

    function automatic logic same_page(line_t a, line_t b);
        return a[LINE_W-1:PAGE_LOG2] == b[LINE_W-1:PAGE_LOG2];
    endfunction

    function automatic stream_t fresh_entry(line_t line, logic [1:0] kind);
        stream_t e;
        e           = '0;
        e.valid     = 1'b1;
        e.kind      = kind;
        e.last      = line;
        return e;
    endfunction

endpackage

// File: rtl/pf_match.sv
module pf_match
    import pf_pkg::*;
(
    input  stream_t    ent,
    input  line_t      line,
    input  logic [1:0] kind,
    output cls_t       cls
);
    line_t fwd;
    line_t bwd;
    logic  f1, f2, b1, b2, up_ok, dn_ok, step;

    always_comb begin
        fwd   = line - ent.last;
        bwd   = ent.last - line;
        f1    = (fwd == line_t'(1));
        f2    = (fwd == line_t'(2));
        b1    = (bwd == line_t'(1));
        b2    = (bwd == line_t'(2));
        up_ok = !ent.dir_known || ent.up;
        dn_ok = !ent.dir_known || !ent.up;
        step  = (up_ok && (f1 || f2)) || (dn_ok && (b1 || b2));
        cls.same = (fwd == '0);
        cls.up   = f1 || f2;
        cls.far  = f2 || b2;
        cls.hit  = ent.valid && (ent.kind == kind) && (cls.same || step);
    end
endmodule

// File: rtl/pf_lru.sv
module pf_lru #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch,
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] victim
);
    logic [IW-1:0] age [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == idx)        age[i] <= '0;
                else if (age[i] < age[idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++)
            if (age[i] == IW'(N - 1)) victim = IW'(i);
    end
endmodule

// File: rtl/pf_issue.sv
module pf_issue
    import pf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  trig,
    input  line_t trig_line,
    input  logic  l2_hit,
    output logic  l2q_valid,
    output line_t l2q_line,
    output logic  pf_valid,
    output line_t pf_line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            l2q_valid <= 1'b0;
            l2q_line  <= '0;
            pf_valid  <= 1'b0;
            pf_line   <= '0;
        end else begin
            l2q_valid <= trig;
            if (trig) l2q_line <= trig_line;
            pf_valid  <= l2q_valid && !l2_hit;
            if (l2q_valid) pf_line <= l2q_line;
        end
    end
endmodule

// File: rtl/pf_stream_prefetcher.sv
module pf_stream_prefetcher
    import pf_pkg::*;
#(
    parameter int NUM_STREAMS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic [1:0]        acc_kind,
    input  logic              l2_hit,
    output logic              l2q_valid,
    output logic [LINE_W-1:0] l2q_line,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line
);
    localparam int IW = $clog2(NUM_STREAMS);

    stream_t       tbl [NUM_STREAMS];
    cls_t          cls [NUM_STREAMS];
    logic          any_hit;
    logic [IW-1:0] sel, victim, wr_idx;
    cls_t          sc;
    stream_t       cur, nxt;
    line_t         tline;
    logic          trig;

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_match
        pf_match u_match (
            .ent  (tbl[g]),
            .line (acc_line),
            .kind (acc_kind),
            .cls  (cls[g])
        );
    end

    // Lowest-numbered matching entry wins.
    always_comb begin
        any_hit = 1'b0;
        sel     = '0;
        for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
            if (cls[i].hit) begin
                any_hit = 1'b1;
                sel     = IW'(i);
            end
        end
    end

    always_comb begin
        sc    = cls[sel];
        cur   = tbl[sel];
        nxt   = cur;
        trig  = 1'b0;
        tline = '0;
        if (!any_hit) begin
            nxt = fresh_entry(acc_line, acc_kind);
        end else if (!sc.same) begin
            if (sc.far && cur.gapped) begin
                nxt = fresh_entry(acc_line, acc_kind);
            end else begin
                nxt.last      = acc_line;
                nxt.dir_known = 1'b1;
                nxt.up        = sc.up;
                nxt.gapped    = cur.gapped || sc.far;
                nxt.hits      = (cur.hits == CNT_W'(CONF_HITS)) ? cur.hits
                                                                 : cur.hits + 1'b1;
                tline         = sc.up ? acc_line + 1'b1 : acc_line - 1'b1;
                trig          = (nxt.hits == CNT_W'(CONF_HITS)) &&
                                same_page(tline, acc_line);
            end
        end
        wr_idx = any_hit ? sel : victim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_STREAMS; i++) tbl[i] <= '0;
        end else if (acc_valid) begin
            tbl[wr_idx] <= nxt;
        end
    end

    pf_lru #(.N(NUM_STREAMS)) u_lru (
        .clk    (clk),
        .rst    (rst),
        .touch  (acc_valid),
        .idx    (wr_idx),
        .victim (victim)
    );

    pf_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .trig      (acc_valid && trig),
        .trig_line (tline),
        .l2_hit    (l2_hit),
        .l2q_valid (l2q_valid),
        .l2q_line  (l2q_line),
        .pf_valid  (pf_valid),
        .pf_line   (pf_line)
    );
endmodule

// File: rtl/pf_prefetch_checks.sv
module pf_prefetch_checks
    import pf_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  acc_valid,
    input line_t acc_line,
    input logic  l2_hit,
    input logic  l2q_valid,
    input line_t l2q_line,
    input logic  pf_valid,
    input line_t pf_line
);
    localparam int SEEN_W = $clog2(CONF_HITS + 2);
    logic [SEEN_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else if (acc_valid && seen != SEEN_W'(CONF_HITS + 1)) seen <= seen + 1'b1;
    end

    // R2: a query only follows an access
    assert_query_after_access_R2: assert property (@(posedge clk) disable iff (rst)
        l2q_valid |-> $past(acc_valid));

    // R2: no query before enough accesses since reset
    assert_no_early_confirm_R2: assert property (@(posedge clk) disable iff (rst)
        l2q_valid |-> seen == SEEN_W'(CONF_HITS + 1));

    // R3: the queried line neighbours the triggering access
    assert_query_adjacent_R3: assert property (@(posedge clk) disable iff (rst)
        l2q_valid |-> (l2q_line == $past(acc_line) + 1'b1 ||
                       l2q_line == $past(acc_line) - 1'b1));

    // R9: the query stays inside the page of the access
    assert_query_in_page_R9: assert property (@(posedge clk) disable iff (rst)
        l2q_valid |-> l2q_line[LINE_W-1:PAGE_LOG2] == $past(acc_line[LINE_W-1:PAGE_LOG2]));

    // R8: a prefetch follows a missed query for the same line
    assert_prefetch_on_miss_R8: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> ($past(l2q_valid && !l2_hit) && pf_line == $past(l2q_line)));

    // R8: a missed query always produces a prefetch
    assert_miss_issues_R8: assert property (@(posedge clk) disable iff (rst)
        (l2q_valid && !l2_hit) |=> pf_valid);
endmodule

bind pf_stream_prefetcher pf_prefetch_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_line  (acc_line),
    .l2_hit    (l2_hit),
    .l2q_valid (l2q_valid),
    .l2q_line  (l2q_line),
    .pf_valid  (pf_valid),
    .pf_line   (pf_line)
);

// File: tb/pf_stream_prefetcher_bench.sv
module pf_stream_prefetcher_bench;
    import pf_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  acc_valid = 1'b0;
    line_t acc_line = '0;
    logic [1:0] acc_kind = 2'd0;
    logic  l2_hit = 1'b0;
    logic  l2q_valid, pf_valid;
    line_t l2q_line, pf_line;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pf_stream_prefetcher u_pf_stream_prefetcher (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_line  (acc_line),
        .acc_kind  (acc_kind),
        .l2_hit    (l2_hit),
        .l2q_valid (l2q_valid),
        .l2q_line  (l2q_line),
        .pf_valid  (pf_valid),
        .pf_line   (pf_line)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        acc_valid = 1'b0;
        l2_hit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One access; query sampled one cycle later, prefetch two cycles later.
    task automatic acc(input line_t line, input logic [1:0] kind, input bit exp_q,
                       input line_t exp_line, input bit hit, input string req);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_line  = line;
        acc_kind  = kind;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(req, l2q_valid, exp_q);
        if (exp_q) chk(req, l2q_line, exp_line);
        l2_hit = hit;
        @(negedge clk);
        chk(req, pf_valid, exp_q && !hit);
        if (exp_q && !hit) chk(req, pf_line, exp_line);
        l2_hit = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 query idle", l2q_valid, 0);
        chk("R1 prefetch idle", pf_valid, 0);
    endtask

    task automatic t_ascend();
        line_t b = line_t'(26'h1000 + 10);
        do_reset();
        for (int i = 0; i < 7; i++)
            acc(b + line_t'(i), KIND_LOAD, i >= 4, b + line_t'(i + 1), 0, "R2 ascending");
    endtask

    task automatic t_descend();
        line_t b = line_t'(26'h2000 + 60);
        do_reset();
        for (int i = 0; i < 7; i++)
            acc(b - line_t'(i), KIND_LOAD, i >= 4, b - line_t'(i + 1), 0, "R3 descending");
    endtask

    task automatic t_gap();
        line_t b = line_t'(26'h3000 + 20);
        do_reset();
        acc(b + 1, KIND_LOAD, 0, '0, 0, "R4 gap run");
        acc(b + 2, KIND_LOAD, 0, '0, 0, "R4 gap run");
        acc(b + 4, KIND_LOAD, 0, '0, 0, "R4 gap run");
        acc(b + 5, KIND_LOAD, 0, '0, 0, "R4 gap run");
        acc(b + 6, KIND_LOAD, 1, b + 7, 0, "R4 gap run confirms");
        acc(b + 7, KIND_LOAD, 1, b + 8, 0, "R4 gap run continues");
    endtask

    task automatic t_sparse();
        line_t b = line_t'(26'h4000 + 20);
        line_t c = line_t'(26'h4200 + 20);
        do_reset();
        acc(b + 1, KIND_LOAD, 0, '0, 0, "R5 sparse");
        acc(b + 3, KIND_LOAD, 0, '0, 0, "R5 sparse");
        acc(b + 6, KIND_LOAD, 0, '0, 0, "R5 sparse");
        acc(b + 9, KIND_LOAD, 0, '0, 0, "R5 sparse");
        for (int i = 0; i < 6; i++)
            acc(c + line_t'(1 + 2 * i), KIND_LOAD, 0, '0, 0, "R5 double gap resets");
    endtask

    task automatic t_repeat();
        line_t b = line_t'(26'h5000 + 30);
        do_reset();
        acc(b,     KIND_LOAD, 0, '0, 0, "R6 repeat");
        acc(b,     KIND_LOAD, 0, '0, 0, "R6 repeat");
        acc(b + 1, KIND_LOAD, 0, '0, 0, "R6 repeat");
        acc(b + 2, KIND_LOAD, 0, '0, 0, "R6 repeat");
        acc(b + 2, KIND_LOAD, 0, '0, 0, "R6 repeat ignored");
        acc(b + 3, KIND_LOAD, 0, '0, 0, "R6 repeat not counted");
        acc(b + 4, KIND_LOAD, 1, b + 5, 0, "R6 confirm after repeats");
    endtask

    task automatic t_kind();
        line_t b = line_t'(26'h6000 + 10);
        line_t f = line_t'(26'h6200 + 10);
        line_t s = line_t'(26'h6400 + 10);
        do_reset();
        for (int i = 0; i < 4; i++)
            acc(b + line_t'(i), KIND_LOAD, 0, '0, 0, "R7 load run");
        acc(b + 4, KIND_STORE, 0, '0, 0, "R7 store does not join load run");
        acc(b + 4, KIND_LOAD, 1, b + 5, 0, "R7 load run confirms");
        for (int i = 0; i < 5; i++)
            acc(f + line_t'(i), KIND_FETCH, i == 4, f + 5, 0, "R7 fetch run");
        for (int i = 0; i < 5; i++)
            acc(s - line_t'(i), KIND_STORE, i == 4, s - 5, 0, "R7 store run");
    endtask

    task automatic t_l2();
        line_t b = line_t'(26'h7000 + 10);
        do_reset();
        for (int i = 0; i < 4; i++)
            acc(b + line_t'(i), KIND_LOAD, 0, '0, 0, "R8 warm up");
        acc(b + 4, KIND_LOAD, 1, b + 5, 1, "R8 present line not fetched");
        acc(b + 5, KIND_LOAD, 1, b + 6, 0, "R8 absent line fetched");
    endtask

    task automatic t_page();
        line_t p = line_t'(26'h8000);
        line_t q = line_t'(26'h8400);
        do_reset();
        for (int i = 5; i >= 2; i--)
            acc(p - line_t'(i), KIND_LOAD, 0, '0, 0, "R9 up to page end");
        acc(p - 1, KIND_LOAD, 0, '0, 0, "R9 crossing upwards suppressed");
        acc(p,     KIND_LOAD, 1, p + 1, 0, "R9 inside next page");
        for (int i = 4; i >= 1; i--)
            acc(q + line_t'(i), KIND_LOAD, 0, '0, 0, "R9 down to page start");
        acc(q, KIND_LOAD, 0, '0, 0, "R9 crossing downwards suppressed");
    endtask

    task automatic t_multi();
        do_reset();
        for (int r = 0; r < 6; r++)
            for (int k = 0; k < 8; k++)
                acc(line_t'(26'h9000 + 256 * k + 10 + r), KIND_LOAD, r >= 4,
                    line_t'(26'h9000 + 256 * k + 11 + r), 0, "R10 interleaved");
    endtask

    task automatic t_lru();
        line_t b = line_t'(26'hA000 + 10);
        do_reset();
        for (int k = 0; k < 8; k++)
            acc(b + line_t'(256 * k), KIND_LOAD, 0, '0, 0, "R11 fill");
        acc(b + 1, KIND_LOAD, 0, '0, 0, "R11 refresh run 0");
        acc(b + line_t'(256 * 8), KIND_LOAD, 0, '0, 0, "R11 evict");
        acc(b + 2, KIND_LOAD, 0, '0, 0, "R11 kept run");
        acc(b + 3, KIND_LOAD, 0, '0, 0, "R11 kept run");
        acc(b + 4, KIND_LOAD, 1, b + 5, 0, "R11 kept run confirms");
        for (int i = 1; i <= 4; i++)
            acc(b + line_t'(256 + i), KIND_LOAD, 0, '0, 0, "R11 evicted run restarts");
        acc(b + line_t'(256 + 5), KIND_LOAD, 1, b + line_t'(256 + 6), 0,
            "R11 evicted run confirms late");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_ascend();
        t_descend();
        t_gap();
        t_sparse();
        t_repeat();
        t_kind();
        t_l2();
        t_page();
        t_multi();
        t_lru();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule